// File: doc/BRIEF.md
# Condition register logic unit

This block keeps a 32-bit condition register split into eight 4-bit fields, together with a 32-bit exception register whose top bits record overflow and carry status. Each cycle in which the valid strobe is high it carries out one operation chosen by a 4-bit code. The operations are:

- a load of the whole condition register;
- a copy of one field into another;
- a load of the exception register;
- a move of the exception register's top three bits into a chosen field, which also clears the exception register;
- eight single-bit boolean operations, each combining two chosen condition bits into a chosen destination bit.

Both registers are visible on the outputs at all times, so a full read needs no extra cycle.

Bits are numbered from the most significant end. A 5-bit bit index therefore selects register bit 31 minus the index. A 3-bit field index selects a nibble counted from the top of the register. The block does no branch decoding and no compares, and it has no pipeline interlocks. The issuing logic supplies one operation per valid cycle.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both cr_q and xr_q to zero on the next edge.
- R2: Op code 0x0 with valid high loads wdata into cr_q. cr_q then shows exactly that value from the next cycle on, for example 0xAAAAAAAA and 0x55555555.
- R3: Bit index i addresses cr_q bit (31 - i), so index 0 is the MSB and index 16 is bit 15. Field index f addresses cr_q[31-4f : 28-4f], so field 0 is the top nibble and field 7 is the bottom nibble.
- R4: Op code 0x2 copies field fld_src into field fld_dst and leaves the other seven fields unchanged. Starting from 0x01234567, copying field 0 to field 4 gives 0x01230567, and copying field 7 to field 0 gives 0x71234567.
- R5: Op code 0x4 loads xr_in into xr_q and leaves cr_q unchanged.
- R6: Op code 0x3 writes field fld_dst as {xr_q[31:29], 0}, leaves the other fields unchanged, and clears xr_q to zero. An xr_q of 0xA0000000 moved into field 1 makes that field 0xA.
- R7: Op codes 0x8 to 0xF write bit bt_dst with f(A,B), where A is the bit at bt_a and B is the bit at bt_b. The functions by code are: 0x8 A&B, 0x9 A&~B, 0xA A|B, 0xB A|~B, 0xC A^B, 0xD ~(A&B), 0xE ~(A|B), 0xF ~(A^B). With cr_q = 0x0000FFFF, code 0x8 with dst 0 and sources 16 and 17 gives 0x8000FFFF.
- R8: When the destination bit is also a source, the operation uses the source values from before the update. With cr_q = 0x0000FFFF and bit 0 as both sources and destination, code 0xC leaves 0x0000FFFF and code 0xF gives 0x8000FFFF.
- R9: With valid low, or with op codes 0x1 (read), 0x5, 0x6 or 0x7, both registers keep their values.
- R10: A bit operation changes no condition bit other than its destination and leaves xr_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Executes op this cycle |
| op | input | 4 | Operation code |
| bt_dst | input | 5 | Destination bit index (MSB = 0) |
| bt_a | input | 5 | First source bit index |
| bt_b | input | 5 | Second source bit index |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index |
| wdata | input | 32 | Value for a full condition register load |
| xr_in | input | 32 | Value for an exception register load |
| cr_q | output | 32 | Current condition register |
| xr_q | output | 32 | Current exception register |

## Verification
The bench builds the block with its default parameters: eight 4-bit fields, a 32-bit exception register and three moved status bits. With these values a 5-bit bit index reaches every register bit and a 3-bit field index reaches every field. Random sources, destinations and op codes therefore cover the full index space, including the cases where the destination overlaps a source. The three moved bits leave one cleared bit in the destination field, and the bench checks that this bit reads zero.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_READ  = 4'h1;
  localparam logic [3:0] OP_FCOPY = 4'h2;
  localparam logic [3:0] OP_XMOVE = 4'h3;
  localparam logic [3:0] OP_XLOAD = 4'h4;

  // Bit operations occupy 0x8..0xF; the low three bits choose the function.
  localparam logic [2:0] BF_AND  = 3'd0;
  localparam logic [2:0] BF_ANDC = 3'd1;
  localparam logic [2:0] BF_OR   = 3'd2;
  localparam logic [2:0] BF_ORC  = 3'd3;
  localparam logic [2:0] BF_XOR  = 3'd4;
  localparam logic [2:0] BF_NAND = 3'd5;
  localparam logic [2:0] BF_NOR  = 3'd6;
  localparam logic [2:0] BF_EQV  = 3'd7;

  function automatic logic cr_bool(input logic [2:0] sel, input logic a, input logic b);
    logic r;
    case (sel)
      BF_AND:  r = a & b;
      BF_ANDC: r = a & ~b;
      BF_OR:   r = a | b;
      BF_ORC:  r = a | ~b;
      BF_XOR:  r = a ^ b;
      BF_NAND: r = ~(a & b);
      BF_NOR:  r = ~(a | b);
      default: r = ~(a ^ b);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cr_op_decode.sv
module cr_op_decode
  import cr_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  output logic       ev_write,
  output logic       ev_fcopy,
  output logic       ev_xmove,
  output logic       ev_xload,
  output logic       ev_bitop,
  output logic       ev_hold
);
  always_comb begin
    ev_write = 1'b0;
    ev_fcopy = 1'b0;
    ev_xmove = 1'b0;
    ev_xload = 1'b0;
    ev_bitop = 1'b0;
    ev_hold  = 1'b0;
    if (valid) begin
      if (op[3]) begin
        ev_bitop = 1'b1;
      end else begin
        case (op)
          OP_WRITE: ev_write = 1'b1;
          OP_FCOPY: ev_fcopy = 1'b1;
          OP_XMOVE: ev_xmove = 1'b1;
          OP_XLOAD: ev_xload = 1'b1;
          default:  ev_hold  = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/cr_bit_unit.sv
module cr_bit_unit
  import cr_pkg::*;
#(
  parameter int CR_W   = 32,
  parameter int BIDX_W = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]   cr_in,
  input  logic [2:0]        fn_sel,
  input  logic [BIDX_W-1:0] idx_dst,
  input  logic [BIDX_W-1:0] idx_a,
  input  logic [BIDX_W-1:0] idx_b,
  output logic              bit_a,
  output logic              bit_b,
  output logic              bit_res,
  output logic [CR_W-1:0]   cr_out
);
  localparam logic [BIDX_W-1:0] TOP_POS = BIDX_W'(CR_W - 1);

  logic [BIDX_W-1:0] pos_dst, pos_a, pos_b;

  // Index 0 names the most significant bit.
  assign pos_dst = TOP_POS - idx_dst;
  assign pos_a   = TOP_POS - idx_a;
  assign pos_b   = TOP_POS - idx_b;

  // Sources are read from the register before the update.
  assign bit_a   = cr_in[pos_a];
  assign bit_b   = cr_in[pos_b];
  assign bit_res = cr_bool(fn_sel, bit_a, bit_b);

  always_comb begin
    cr_out          = cr_in;
    cr_out[pos_dst] = bit_res;
  end
endmodule

// File: rtl/cr_field_unit.sv
module cr_field_unit #(
  parameter int FIELDS  = 8,
  parameter int FIELD_W = 4,
  parameter int XR_TOP  = 3,
  parameter int CR_W    = FIELDS * FIELD_W,
  parameter int FIDX_W  = $clog2(FIELDS)
) (
  input  logic [CR_W-1:0]   cr_in,
  input  logic [FIDX_W-1:0] fdst,
  input  logic [FIDX_W-1:0] fsrc,
  input  logic [XR_TOP-1:0] xr_top,
  output logic [CR_W-1:0]   copy_out,
  output logic [CR_W-1:0]   xmove_out
);
  localparam int PAD_W = FIELD_W - XR_TOP;

  logic [FIELD_W-1:0] fld_vals [FIELDS];
  logic [FIELD_W-1:0] moved_fld;
  logic [FIELD_W-1:0] copied_fld;

  assign moved_fld  = {xr_top, {PAD_W{1'b0}}};
  assign copied_fld = fld_vals[fsrc];

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    localparam int HI = CR_W - 1 - f * FIELD_W;
    assign fld_vals[f] = cr_in[HI -: FIELD_W];
    assign copy_out[HI -: FIELD_W]  = (fdst == FIDX_W'(f)) ? copied_fld : fld_vals[f];
    assign xmove_out[HI -: FIELD_W] = (fdst == FIDX_W'(f)) ? moved_fld  : fld_vals[f];
  end
endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit #(
  parameter int FIELDS  = 8,
  parameter int FIELD_W = 4,
  parameter int XR_W    = 32,
  parameter int XR_TOP  = 3,
  localparam int CR_W   = FIELDS * FIELD_W,
  localparam int BIDX_W = $clog2(CR_W),
  localparam int FIDX_W = $clog2(FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [3:0]        op,
  input  logic [BIDX_W-1:0] bt_dst,
  input  logic [BIDX_W-1:0] bt_a,
  input  logic [BIDX_W-1:0] bt_b,
  input  logic [FIDX_W-1:0] fld_dst,
  input  logic [FIDX_W-1:0] fld_src,
  input  logic [CR_W-1:0]   wdata,
  input  logic [XR_W-1:0]   xr_in,
  output logic [CR_W-1:0]   cr_q,
  output logic [XR_W-1:0]   xr_q
);
  logic ev_write, ev_fcopy, ev_xmove, ev_xload, ev_bitop, ev_hold;
  logic bit_a, bit_b, bit_res;
  logic [CR_W-1:0] bit_next, copy_next, xmove_next, cr_d;
  logic [XR_W-1:0] xr_d;

  cr_op_decode u_dec (
    .valid    (valid),
    .op       (op),
    .ev_write (ev_write),
    .ev_fcopy (ev_fcopy),
    .ev_xmove (ev_xmove),
    .ev_xload (ev_xload),
    .ev_bitop (ev_bitop),
    .ev_hold  (ev_hold)
  );

  cr_bit_unit #(.CR_W(CR_W), .BIDX_W(BIDX_W)) u_bit (
    .cr_in   (cr_q),
    .fn_sel  (op[2:0]),
    .idx_dst (bt_dst),
    .idx_a   (bt_a),
    .idx_b   (bt_b),
    .bit_a   (bit_a),
    .bit_b   (bit_b),
    .bit_res (bit_res),
    .cr_out  (bit_next)
  );

  cr_field_unit #(
    .FIELDS(FIELDS), .FIELD_W(FIELD_W), .XR_TOP(XR_TOP),
    .CR_W(CR_W), .FIDX_W(FIDX_W)
  ) u_fld (
    .cr_in     (cr_q),
    .fdst      (fld_dst),
    .fsrc      (fld_src),
    .xr_top    (xr_q[XR_W-1 -: XR_TOP]),
    .copy_out  (copy_next),
    .xmove_out (xmove_next)
  );

  always_comb begin
    cr_d = cr_q;
    xr_d = xr_q;
    if (ev_write) cr_d = wdata;
    if (ev_fcopy) cr_d = copy_next;
    if (ev_bitop) cr_d = bit_next;
    if (ev_xload) xr_d = xr_in;
    if (ev_xmove) begin
      cr_d = xmove_next;
      xr_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q <= '0;
      xr_q <= '0;
    end else begin
      cr_q <= cr_d;
      xr_q <= xr_d;
    end
  end
endmodule

// File: rtl/cr_logic_unit_chk.sv
module cr_logic_unit_chk
  import cr_pkg::*;
#(
  parameter int FIELDS  = 8,
  parameter int FIELD_W = 4,
  parameter int XR_W    = 32,
  parameter int XR_TOP  = 3,
  localparam int CR_W   = FIELDS * FIELD_W,
  localparam int BIDX_W = $clog2(CR_W),
  localparam int FIDX_W = $clog2(FIELDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic [3:0]        op,
  input logic [BIDX_W-1:0] bt_dst,
  input logic [BIDX_W-1:0] bt_a,
  input logic [BIDX_W-1:0] bt_b,
  input logic [FIDX_W-1:0] fld_dst,
  input logic [FIDX_W-1:0] fld_src,
  input logic [CR_W-1:0]   wdata,
  input logic [XR_W-1:0]   xr_in,
  input logic [CR_W-1:0]   cr_q,
  input logic [XR_W-1:0]   xr_q,
  input logic              ev_write,
  input logic              ev_fcopy,
  input logic              ev_xmove,
  input logic              ev_xload,
  input logic              ev_bitop,
  input logic              ev_hold
);
  function automatic logic [FIELD_W-1:0] fget(input logic [CR_W-1:0] v, input logic [FIDX_W-1:0] i);
    return v[CR_W - 1 - int'(i) * FIELD_W -: FIELD_W];
  endfunction

  function automatic logic bget(input logic [CR_W-1:0] v, input logic [BIDX_W-1:0] i);
    return v[CR_W - 1 - int'(i)];
  endfunction

  logic idle_cycle;
  assign idle_cycle = !valid || (op == OP_READ) || (op == 4'h5) || (op == 4'h6) || (op == 4'h7);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cr_q == '0 && xr_q == '0));

  a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WRITE) |=> cr_q == $past(wdata));

  a_r4_field_copy: assert property (@(posedge clk) disable iff (rst)
    ev_fcopy |=> fget(cr_q, $past(fld_dst)) == fget($past(cr_q), $past(fld_src)));

  a_r5_xr_load: assert property (@(posedge clk) disable iff (rst)
    ev_xload |=> (xr_q == $past(xr_in) && $stable(cr_q)));

  a_r6_xr_cleared: assert property (@(posedge clk) disable iff (rst)
    ev_xmove |=> xr_q == '0);

  a_r6_field_moved: assert property (@(posedge clk) disable iff (rst)
    ev_xmove |=> fget(cr_q, $past(fld_dst)) ==
      {$past(xr_q[XR_W-1 -: XR_TOP]), {(FIELD_W-XR_TOP){1'b0}}});

  a_r7_bit_result: assert property (@(posedge clk) disable iff (rst)
    ev_bitop |=> bget(cr_q, $past(bt_dst)) ==
      cr_bool($past(op[2:0]), bget($past(cr_q), $past(bt_a)), bget($past(cr_q), $past(bt_b))));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    idle_cycle |=> ($stable(cr_q) && $stable(xr_q)));

  a_r10_single_bit: assert property (@(posedge clk) disable iff (rst)
    ev_bitop |=> ($countones(cr_q ^ $past(cr_q)) <= 1 && $stable(xr_q)));

  a_r9_events_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_write, ev_fcopy, ev_xmove, ev_xload, ev_bitop, ev_hold}));
endmodule

bind cr_logic_unit cr_logic_unit_chk #(
  .FIELDS(FIELDS), .FIELD_W(FIELD_W), .XR_W(XR_W), .XR_TOP(XR_TOP)
) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op),
  .bt_dst(bt_dst), .bt_a(bt_a), .bt_b(bt_b),
  .fld_dst(fld_dst), .fld_src(fld_src),
  .wdata(wdata), .xr_in(xr_in), .cr_q(cr_q), .xr_q(xr_q),
  .ev_write(ev_write), .ev_fcopy(ev_fcopy), .ev_xmove(ev_xmove),
  .ev_xload(ev_xload), .ev_bitop(ev_bitop), .ev_hold(ev_hold)
);

// File: tb/cr_logic_unit_tb.sv
`timescale 1ns/1ps
module cr_logic_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'h1;
  logic [4:0]  bt_dst = '0, bt_a = '0, bt_b = '0;
  logic [2:0]  fld_dst = '0, fld_src = '0;
  logic [31:0] wdata = '0, xr_in = '0;
  logic [31:0] cr_q, xr_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_cr = '0;
  logic [31:0] m_xr = '0;

  always #2 clk = ~clk;

  cr_logic_unit u_dut (
    .clk(clk), .rst(rst), .valid(valid), .op(op),
    .bt_dst(bt_dst), .bt_a(bt_a), .bt_b(bt_b),
    .fld_dst(fld_dst), .fld_src(fld_src),
    .wdata(wdata), .xr_in(xr_in), .cr_q(cr_q), .xr_q(xr_q)
  );

  // Truth tables indexed by {A,B}, one per function code 0..7.
  function automatic logic tt_eval(input logic [2:0] fn, input logic a, input logic b);
    logic [3:0] tbl [8];
    tbl[0] = 4'b1000; tbl[1] = 4'b0100; tbl[2] = 4'b1110; tbl[3] = 4'b1101;
    tbl[4] = 4'b0110; tbl[5] = 4'b0111; tbl[6] = 4'b0001; tbl[7] = 4'b1001;
    return tbl[fn][{a, b}];
  endfunction

  function automatic logic [31:0] nib_put(input logic [31:0] v, input int f, input logic [3:0] n);
    int sh = 28 - 4 * f;
    return (v & ~(32'hF << sh)) | (32'(n) << sh);
  endfunction

  function automatic logic [3:0] nib_get(input logic [31:0] v, input int f);
    return 4'((v >> (28 - 4 * f)) & 32'hF);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic model_apply();
    logic a, b;
    if (!valid) return;
    if (op[3]) begin
      a = m_cr[31 - int'(bt_a)];
      b = m_cr[31 - int'(bt_b)];
      m_cr[31 - int'(bt_dst)] = tt_eval(op[2:0], a, b);
    end else begin
      case (op)
        4'h0: m_cr = wdata;
        4'h2: m_cr = nib_put(m_cr, int'(fld_dst), nib_get(m_cr, int'(fld_src)));
        4'h3: begin
          m_cr = nib_put(m_cr, int'(fld_dst), {m_xr[31:29], 1'b0});
          m_xr = '0;
        end
        4'h4: m_xr = xr_in;
        default: ;
      endcase
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic v, input logic [3:0] o, input logic [4:0] d, input logic [4:0] a,
                      input logic [4:0] b, input logic [2:0] fd, input logic [2:0] fs,
                      input logic [31:0] wd, input logic [31:0] xi, input string req);
    logic [31:0] prev_cr;
    valid = v; op = o; bt_dst = d; bt_a = a; bt_b = b;
    fld_dst = fd; fld_src = fs; wdata = wd; xr_in = xi;
    prev_cr = m_cr;
    model_apply();
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    check(req, "cr_q", cr_q, m_cr);
    check(req, "xr_q", xr_q, m_xr);
    if (v && o[3]) begin
      checks++;
      if ($countones(cr_q ^ prev_cr) > 1) begin
        errors++;
        $display("FAIL R10 bits changed: actual %08h expected at most one bit vs %08h", cr_q, prev_cr);
      end
    end
  endtask

  task automatic wr(input logic [31:0] v, input string req);
    step(1'b1, 4'h0, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, v, 32'h0, req);
  endtask

  task automatic bop(input logic [3:0] o, input logic [4:0] d, input logic [4:0] a,
                     input logic [4:0] b, input string req);
    step(1'b1, o, d, a, b, 3'd0, 3'd0, 32'h0, 32'h0, req);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    string tag;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "cr_q after reset", cr_q, 32'h0);
    check("R1", "xr_q after reset", xr_q, 32'h0);
    rst = 1'b0;

    // R2: full load and read-back
    wr(32'hAAAAAAAA, "R2");
    check("R2", "read AAAA", cr_q, 32'hAAAAAAAA);
    wr(32'h55555555, "R2");
    check("R2", "read 5555", cr_q, 32'h55555555);

    // R3 / R7: MSB-first numbering and the AND example
    wr(32'h0000FFFF, "R2");
    bop(4'h8, 5'd0, 5'd16, 5'd17, "R7");
    check("R3", "and 16,17 into 0", cr_q, 32'h8000FFFF);
    wr(32'h0000FFFF, "R2");
    bop(4'h8, 5'd0, 5'd0, 5'd16, "R7");
    check("R7", "and 0,16 into 0", cr_q, 32'h0000FFFF);

    // R8: destination overlaps sources
    wr(32'h0000FFFF, "R2");
    bop(4'hC, 5'd0, 5'd0, 5'd0, "R8");
    check("R8", "xor self", cr_q, 32'h0000FFFF);
    bop(4'hF, 5'd0, 5'd0, 5'd0, "R8");
    check("R8", "eqv self", cr_q, 32'h8000FFFF);

    // R7: every function code once from 0x0000FFFF, bit 0 with bit 16
    for (int k = 8; k < 16; k++) begin
      wr(32'h0000FFFF, "R2");
      bop(4'(k), 5'd0, 5'd0, 5'd16, "R7");
    end

    // R4: field copies
    wr(32'h01234567, "R2");
    step(1'b1, 4'h2, 5'd0, 5'd0, 5'd0, 3'd4, 3'd0, 32'h0, 32'h0, "R4");
    check("R4", "copy 0->4", cr_q, 32'h01230567);
    wr(32'h01234567, "R2");
    step(1'b1, 4'h2, 5'd0, 5'd0, 5'd0, 3'd0, 3'd7, 32'h0, 32'h0, "R4");
    check("R4", "copy 7->0", cr_q, 32'h71234567);

    // R5 / R6: exception register load and move
    wr(32'h00000000, "R2");
    step(1'b1, 4'h4, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h0, 32'hA0000000, "R5");
    check("R5", "xr load", xr_q, 32'hA0000000);
    step(1'b1, 4'h3, 5'd0, 5'd0, 5'd0, 3'd1, 3'd0, 32'h0, 32'h0, "R6");
    check("R6", "field 1 after move", cr_q, 32'h0A000000);
    check("R6", "xr cleared", xr_q, 32'h0);
    wr(32'hFFFFFFFF, "R2");
    step(1'b1, 4'h4, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h0, 32'h40000000, "R5");
    step(1'b1, 4'h3, 5'd0, 5'd0, 5'd0, 3'd5, 3'd0, 32'h0, 32'h0, "R6");
    check("R6", "field 5 after move", cr_q, 32'hFFFFF4FF);

    // R9: idle cycles, read code and unused codes
    step(1'b1, 4'h4, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h0, 32'hE1234567, "R5");
    step(1'b0, 4'h0, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h12345678, 32'h0, "R9");
    step(1'b0, 4'h3, 5'd0, 5'd0, 5'd0, 3'd2, 3'd0, 32'h0, 32'h0, "R9");
    step(1'b1, 4'h1, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h0, 32'h0, "R9");
    for (int k = 5; k < 8; k++)
      step(1'b1, 4'(k), 5'd3, 5'd4, 5'd5, 3'd1, 3'd2, 32'hDEADBEEF, 32'h0BADF00D, "R9");
    check("R9", "cr held", cr_q, 32'hFFFFF4FF);
    check("R9", "xr held", xr_q, 32'hE1234567);

    // Random mix; the tag follows the operation class
    for (int n = 0; n < 600; n++) begin
      logic [3:0] o;
      logic v;
      o = 4'($urandom_range(0, 15));
      v = ($urandom_range(0, 9) != 0);
      if (!v) tag = "R9";
      else if (o[3]) tag = "R7";
      else if (o == 4'h0) tag = "R2";
      else if (o == 4'h2) tag = "R4";
      else if (o == 4'h3) tag = "R6";
      else if (o == 4'h4) tag = "R5";
      else tag = "R9";
      step(v, o, 5'($urandom), 5'($urandom), 5'($urandom), 3'($urandom), 3'($urandom),
           $urandom, $urandom, tag);
    end

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cr = '0;
    m_xr = '0;
    check("R1", "cr_q after late reset", cr_q, 32'h0);
    check("R1", "xr_q after late reset", xr_q, 32'h0);

    summary();
  end
endmodule